// File: doc/BRIEF.md
# Processor Bus Peripheral Decoder with Divide-by-22 Clock

This block is the glue logic between an 8-bit processor bus and an external analog acquisition board. It watches four address lines (bit 15 and bits 2..0) and the active-low write line, and produces three outputs:
- an active-low group select for the RAM in the upper half of the address space;
- three active-low write strobes that clock data and control words into the external A/D logic;
- a one-bit readback path, with an output enable, that places either the comparator input or the interference input onto data bit 0.

It also passes the interference flag on as an active-low interrupt. It divides the processor E clock by 22 to make a square-wave clock for the analog board.

The block is clocked by E itself. The strobe and readback decode is combinational and is qualified by E being high. The divider advances on each rising edge of E. The reset is active low and only clears the divider.

Top module: `periph_decoder`

## Requirements
- R1: `ramSelN` is 0 exactly when `addrHi` is 1, independent of E, the write line and the low address bits.
- R2: With `addrHi`=0, `wrN`=0 and E high, `aptN[n]` is 0 when `addrLo`=n for n in {0,1,2}, and every other strobe bit stays 1. Writes to offsets 3..7 assert no strobe. While E is low, all strobes are 1.
- R3: At most one bit of `aptN` is 0 at any time, and none is 0 while `addrHi`=1.
- R4: A read (`wrN`=1, E high, `addrHi`=0) from offset 4 gives `d0Oe`=1 and `d0Out` equal to the level on `compN`.
- R5: A read from offset 5 under the same conditions gives `d0Oe`=1 and `d0Out` equal to the level on `intfN`.
- R6: In every other case `d0Oe` is 0. This covers writes to offsets 4 and 5, other offsets, `addrHi`=1, and E low.
- R7: `intN` equals `intfN` at all times, so the interrupt is asserted (0) while interference is active.
- R8: While `rstN`=0, `cpx` is 0 and the divider count is 0. After release, `cpx` rises on the 11th rising edge of E and then toggles every 11 rising edges. This gives a period of 22 E cycles with 50% duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| eClk | input | 1 | Processor E clock; also the strobe qualifier |
| rstN | input | 1 | Active-low reset of the divider |
| addrHi | input | 1 | Address bit 15 |
| addrLo | input | 3 | Address bits 2..0 (peripheral offset) |
| wrN | input | 1 | Active-low write |
| compN | input | 1 | Active-low comparator input from the analog board |
| intfN | input | 1 | Active-low interference input from the analog board |
| ramSelN | output | 1 | Active-low RAM group select |
| aptN | output | 3 | Active-low A/D write strobes, one per offset 0..2 |
| d0Out | output | 1 | Readback value for data bit 0 |
| d0Oe | output | 1 | Drive enable for data bit 0 (tri-state control) |
| intN | output | 1 | Active-low interrupt |
| cpx | output | 1 | E divided by 22 |

## Verification
Writes are swept over all eight offsets with address bit 15 low and then high. This separates the three real strobe offsets from the five dead ones, and shows that the RAM region blocks the strobes. Reads are swept over all offsets with all four combinations of the comparator and interference levels. This shows that offset 4 and offset 5 select different sources, that both levels pass through unchanged, and that a write to those offsets never turns the driver on. Every item is also checked during the low phase of E to show the qualification. The divider is followed edge by edge from reset over several full periods to pin down the first rise and the 11-edge half period.

// File: rtl/periph_decoder_pkg.sv
package periph_decoder_pkg;
  parameter int unsigned APT_COUNT = 3;
  parameter int unsigned OFS_W     = 3;
  parameter int unsigned COMP_OFS  = 4;
  parameter int unsigned INTF_OFS  = 5;

  typedef struct packed {
    logic                 ramHit;
    logic [APT_COUNT-1:0] aptHit;
    logic                 rdComp;
    logic                 rdIntf;
  } busStrobes_t;
endpackage

// File: rtl/periph_decode_ctl.sv
module periph_decode_ctl
  import periph_decoder_pkg::*;
(
  input  logic             eClk,
  input  logic             rstN,
  input  logic             addrHi,
  input  logic [OFS_W-1:0] addrLo,
  input  logic             wrN,
  output busStrobes_t      strb
);
  logic ioCycle;
  logic wrCycle;
  logic rdCycle;

  assign ioCycle = eClk & ~addrHi;
  assign wrCycle = ioCycle & ~wrN;
  assign rdCycle = ioCycle & wrN;

  assign strb.ramHit = addrHi;
  assign strb.rdComp = rdCycle & (addrLo == OFS_W'(COMP_OFS));
  assign strb.rdIntf = rdCycle & (addrLo == OFS_W'(INTF_OFS));

  for (genvar n = 0; n < APT_COUNT; n++) begin : g_apt
    assign strb.aptHit[n] = wrCycle & (addrLo == OFS_W'(n));
  end

  always_comb begin
    if (rstN === 1'b1) begin
      assert_strobe_excl_R3: assert ($onehot0(strb.aptHit) && !(strb.ramHit && |strb.aptHit));
      assert_read_excl_R4: assert (!(strb.rdComp && strb.rdIntf) && !((strb.rdComp || strb.rdIntf) && |strb.aptHit));
    end
  end
endmodule

// File: rtl/periph_decode_dp.sv
module periph_decode_dp
  import periph_decoder_pkg::*;
#(
  parameter int unsigned DIV = 22
)(
  input  logic                 eClk,
  input  logic                 rstN,
  input  busStrobes_t          strb,
  input  logic                 compN,
  input  logic                 intfN,
  output logic                 ramSelN,
  output logic [APT_COUNT-1:0] aptN,
  output logic                 d0Out,
  output logic                 d0Oe,
  output logic                 intN,
  output logic                 cpx
);
  localparam int unsigned HALF  = DIV / 2;
  localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] divCnt;

  always_ff @(posedge eClk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      cpx    <= 1'b0;
    end else if (divCnt == LAST) begin
      divCnt <= '0;
      cpx    <= ~cpx;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign ramSelN = ~strb.ramHit;
  assign aptN    = ~strb.aptHit;
  assign d0Oe    = strb.rdComp | strb.rdIntf;
  assign d0Out   = (strb.rdComp & compN) | (strb.rdIntf & intfN);
  assign intN    = intfN;

  always_comb begin
    if (rstN === 1'b1) begin
      assert_no_drive_on_write_R6: assert (!(d0Oe && (aptN != '1)) && !(d0Oe && !ramSelN));
    end
  end

  assert_cnt_bound_R8: assert property (@(posedge eClk) disable iff (!rstN)
    divCnt <= LAST);
  assert_toggle_at_wrap_R8: assert property (@(posedge eClk) disable iff (!rstN)
    (divCnt == LAST) |=> (cpx != $past(cpx)));
  assert_hold_between_R8: assert property (@(posedge eClk) disable iff (!rstN)
    (divCnt != LAST) |=> $stable(cpx));
endmodule

// File: rtl/periph_decoder.sv
module periph_decoder
  import periph_decoder_pkg::*;
#(
  parameter int unsigned DIV = 22
)(
  input  logic       eClk,
  input  logic       rstN,
  input  logic       addrHi,
  input  logic [2:0] addrLo,
  input  logic       wrN,
  input  logic       compN,
  input  logic       intfN,
  output logic       ramSelN,
  output logic [2:0] aptN,
  output logic       d0Out,
  output logic       d0Oe,
  output logic       intN,
  output logic       cpx
);
  busStrobes_t strb;

  periph_decode_ctl u_ctl (
    .eClk   (eClk),
    .rstN   (rstN),
    .addrHi (addrHi),
    .addrLo (addrLo),
    .wrN    (wrN),
    .strb   (strb)
  );

  periph_decode_dp #(.DIV(DIV)) u_dp (
    .eClk    (eClk),
    .rstN    (rstN),
    .strb    (strb),
    .compN   (compN),
    .intfN   (intfN),
    .ramSelN (ramSelN),
    .aptN    (aptN),
    .d0Out   (d0Out),
    .d0Oe    (d0Oe),
    .intN    (intN),
    .cpx     (cpx)
  );
endmodule

// File: tb/tb_periph_decoder.sv
`timescale 1ns/1ps
module tb_periph_decoder;
  logic clk = 1'b0;
  logic rstN, addrHi, wrN, compN, intfN;
  logic [2:0] addrLo;
  logic ramSelN, d0Out, d0Oe, intN, cpx;
  logic [2:0] aptN;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic       ramN;
    logic [2:0] apt;
    logic       oe;
    logic       d0;
    logic       irq;
    logic [2:0] ofs;
  } expItem_t;

  expItem_t scb[$];

  always #4 clk = ~clk;

  periph_decoder dut (
    .eClk(clk), .rstN(rstN), .addrHi(addrHi), .addrLo(addrLo), .wrN(wrN),
    .compN(compN), .intfN(intfN), .ramSelN(ramSelN), .aptN(aptN),
    .d0Out(d0Out), .d0Oe(d0Oe), .intN(intN), .cpx(cpx)
  );

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic hi, input logic [2:0] ofs, input logic w,
                       input logic c, input logic f);
    expItem_t it;
    @(negedge clk);
    addrHi = hi; addrLo = ofs; wrN = w; compN = c; intfN = f;
    it.ramN = ~hi;
    it.apt  = 3'b111;
    if (!hi && !w && ofs < 3) it.apt[ofs] = 1'b0;
    it.oe   = !hi && w && (ofs == 3'd4 || ofs == 3'd5);
    it.d0   = it.oe ? ((ofs == 3'd4) ? c : f) : 1'b0;
    it.irq  = f;
    it.ofs  = ofs;
    scb.push_back(it);
    #1;
    chk("R2 low-phase strobes", aptN, 3'b111);
    chk("R6 low-phase enable", {2'b0, d0Oe}, 3'b0);
    chk("R1 low-phase ramSel", {2'b0, ramSelN}, {2'b0, ~hi});
  endtask

  initial begin : monitor
    expItem_t it;
    forever begin
      @(posedge clk);
      #2;
      while (scb.size() > 0) begin
        it = scb.pop_front();
        chk("R1 ramSelN", {2'b0, ramSelN}, {2'b0, it.ramN});
        chk("R2 aptN", aptN, it.apt);
        checks++;
        if (!$onehot0(~aptN)) begin
          failures++;
          $display("FAIL R3 aptN actual=%b expected=at most one low", aptN);
        end
        chk("R6 d0Oe", {2'b0, d0Oe}, {2'b0, it.oe});
        if (it.oe) chk((it.ofs == 3'd4) ? "R4 d0Out" : "R5 d0Out", {2'b0, d0Out}, {2'b0, it.d0});
        chk("R7 intN", {2'b0, intN}, {2'b0, it.irq});
      end
    end
  end

  initial begin : watchdog
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    rstN = 1'b0; addrHi = 1'b1; addrLo = 3'd0; wrN = 1'b1; compN = 1'b1; intfN = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk("R8 cpx in reset", {2'b0, cpx}, 3'b0);
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 1; k <= 70; k++) begin
      @(posedge clk);
      #1 chk($sformatf("R8 cpx edge %0d", k), {2'b0, cpx}, {2'b0, logic'((k / 11) % 2)});
    end
    for (int o = 0; o < 8; o++) drive(1'b0, 3'(o), 1'b0, 1'b1, 1'b1);
    for (int o = 0; o < 8; o++) drive(1'b1, 3'(o), 1'b0, 1'b0, 1'b0);
    for (int v = 0; v < 4; v++)
      for (int o = 0; o < 8; o++) drive(1'b0, 3'(o), 1'b1, v[0], v[1]);
    drive(1'b1, 3'd4, 1'b1, 1'b0, 1'b1);
    drive(1'b1, 3'd5, 1'b1, 1'b1, 1'b0);
    drive(1'b0, 3'd4, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 3'd5, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule